// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks which cache lines currently hold a load-linked reservation and which requester owns each one. A completion stream carries every write-class operation that finishes for a line: load-linked, store-conditional, ordinary write, and the two halves of a locked read-modify-write pair. For each accepted completion the block updates its small reservation table and returns a one-bit outcome. A load-linked always passes and reserves the line. A store-conditional passes only when the same requester still owns the line, and it removes the reservation whatever the outcome. An ordinary write by the owner removes that owner's reservation.

Two more inputs act on the block. An eviction/invalidate input drops any reservation on a line. A bypass input turns reservation handling off, so every completion reports success and the table is left untouched. The block also keeps one blocked line: the read half of a locked pair sets it and the write half clears it. A probe address is compared against that line so the request path can hold off requests to it.

The completion side uses valid/ready. A completion is taken on a clock edge where `cmp_valid` and `cmp_ready` are both high. Its result is registered and shown on `rsp_valid`/`rsp_ok`/`rsp_id` in the following cycle. The result stays unchanged until it is taken on an edge with `rsp_ready` high. `cmp_ready` is low only while an earlier result is waiting and `rsp_ready` is low, so the result register is never overwritten. The eviction, bypass and probe pins are plain control signals with no handshake.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 0) always returns ok=1 and reserves its line for the issuing requester identifier.
- R2: A store-conditional (op code 1) returns ok=1 only if its line is reserved by the same identifier; otherwise it returns ok=0.
- R3: Every store-conditional removes the reservation on its line, whatever its outcome and whichever identifier holds that reservation.
- R4: An ordinary write (op code 2, and also the unused codes 5, 6, 7) always returns ok=1. It removes the reservation on its line only when the writer's identifier owns that reservation. A write by another identifier leaves the reservation in place.
- R5: The table holds at most DEPTH lines, one entry per line. A load-linked to a line that is already reserved gives that entry to the new identifier and makes it the most recent. A load-linked to a new line while the table is full replaces the reservation that was set least recently.
- R6: An eviction pulse removes any reservation on its line. When an eviction and a completion arrive in the same cycle, the eviction is applied first.
- R7: A locked read (op code 3) makes its line the blocked line from the next cycle on. `chk_blocked` is high exactly when the line of `chk_addr` equals the blocked line. A locked write (op code 4) clears the block. Both return ok=1 and act on reservations like an ordinary write.
- R8: While `bypass` is high, every completion returns ok=1 and no reservation is created or removed.
- R9: `cmp_ready` = !rsp_valid || rsp_ready. A result appears the cycle after its completion is accepted and holds steady while `rsp_ready` is low.
- R10: The line address is the address with its low log2(LINE_BYTES) bits dropped, so any two addresses inside one line match.
- R11: After reset the table is empty, no line is blocked, and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Disable reservation handling; all results succeed |
| cmp_valid | input | 1 | Completion present |
| cmp_ready | output | 1 | Completion can be accepted |
| cmp_op | input | 3 | Operation code (0 LL, 1 SC, 2 write, 3 locked read, 4 locked write, 5-7 write) |
| cmp_addr | input | AW | Byte address of the completion |
| cmp_id | input | IDW | Requester identifier |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_ok | output | 1 | 1 = success, 0 = failed store-conditional |
| rsp_id | output | IDW | Identifier of the completion the result belongs to |
| evict_valid | input | 1 | Eviction/invalidate pulse |
| evict_addr | input | AW | Address of the evicted line |
| chk_addr | input | AW | Address probed against the blocked line |
| chk_blocked | output | 1 | Probed line is currently blocked |

## Verification
The bench builds the block with a 16-bit address, 64-byte lines, 4-bit identifiers and a four-entry table. With four entries, a fifth distinct line is enough to force replacement, both from an untouched table and after a refresh has changed the age order. Since the lines are 64 bytes, offsets such as +4, +8 and +16 stay inside one line, so line matching is tested with addresses that differ only in their low bits. The narrow address keeps the line tags short, and every line number used in the bench can be told apart at a glance.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    OP_LL   = 3'd0,
    OP_SC   = 3'd1,
    OP_WR   = 3'd2,
    OP_LKRD = 3'd3,
    OP_LKWR = 3'd4
  } op_e;
endpackage

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LW    = 26,
  parameter int IDW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  input  logic [LW-1:0]  ev_line,
  input  logic           upd_en,
  input  logic [2:0]     upd_op,
  input  logic [LW-1:0]  upd_line,
  input  logic [IDW-1:0] upd_id,
  output logic           hit_own
);
  localparam int AGEW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [LW-1:0]    line_q [DEPTH];
  logic [IDW-1:0]   id_q   [DEPTH];
  logic [AGEW-1:0]  age_q  [DEPTH];

  logic [DEPTH-1:0] ev_hit, v1, same_line, own, clr, v2;
  logic [AGEW-1:0]  rank [DEPTH];
  logic [AGEW-1:0]  tgt;
  logic [AGEW:0]    tgt_rank;
  logic             found, is_ll;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ev_hit[i]    = vld_q[i] && ev_valid && (line_q[i] == ev_line);
      v1[i]        = vld_q[i] && !ev_hit[i];
      same_line[i] = v1[i] && (line_q[i] == upd_line);
      own[i]       = same_line[i] && (id_q[i] == upd_id);
    end
    hit_own = |own;
    is_ll   = upd_en && (upd_op == OP_LL);
    if (!upd_en || upd_op == OP_LL) clr = '0;
    else if (upd_op == OP_SC)       clr = same_line;
    else                            clr = own;
    v2 = v1 & ~clr;
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (v2[j] && (age_q[j] < age_q[i])) rank[i] = rank[i] + 1'b1;
    end
    found = 1'b0;
    tgt   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!found && same_line[i]) begin found = 1'b1; tgt = AGEW'(i); end
    for (int i = 0; i < DEPTH; i++)
      if (!found && !v2[i]) begin found = 1'b1; tgt = AGEW'(i); end
    for (int i = 0; i < DEPTH; i++)
      if (!found && rank[i] == AGEW'(DEPTH - 1)) begin found = 1'b1; tgt = AGEW'(i); end
    tgt_rank = v2[tgt] ? {1'b0, rank[tgt]} : (AGEW+1)'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        id_q[i]   <= '0;
        age_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (is_ll && tgt == AGEW'(i)) begin
          vld_q[i]  <= 1'b1;
          line_q[i] <= upd_line;
          id_q[i]   <= upd_id;
          age_q[i]  <= '0;
        end else begin
          vld_q[i] <= v2[i];
          if (is_ll && v2[i] && ({1'b0, rank[i]} < tgt_rank)) age_q[i] <= rank[i] + 1'b1;
          else                                                age_q[i] <= rank[i];
        end
      end
    end
  end

  // checker state: the last update, compared against the table one cycle later
  logic           chk_ll_q, chk_sc_q;
  logic [LW-1:0]  chk_line_q;
  logic [IDW-1:0] chk_id_q;
  logic           ll_found, line_any, dup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_ll_q <= 1'b0; chk_sc_q <= 1'b0; chk_line_q <= '0; chk_id_q <= '0;
    end else begin
      chk_ll_q   <= upd_en && upd_op == OP_LL;
      chk_sc_q   <= upd_en && upd_op == OP_SC;
      chk_line_q <= upd_line;
      chk_id_q   <= upd_id;
    end
  end

  always_comb begin
    ll_found = 1'b0; line_any = 1'b0; dup = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && line_q[i] == chk_line_q) begin
        line_any = 1'b1;
        if (id_q[i] == chk_id_q) ll_found = 1'b1;
      end
      for (int j = i + 1; j < DEPTH; j++)
        if (vld_q[i] && vld_q[j] && line_q[i] == line_q[j]) dup = 1'b1;
    end
  end

  p_ll_sets_r1: assert property (@(posedge clk) disable iff (!rst_n) chk_ll_q |-> ll_found);
  p_sc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n) chk_sc_q |-> !line_any);
  p_one_entry_per_line_r5: assert property (@(posedge clk) disable iff (!rst_n) !dup);
endmodule

// File: rtl/llsc_line_lock.sv
module llsc_line_lock #(
  parameter int LW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [LW-1:0] line,
  input  logic [LW-1:0] chk_line,
  output logic          chk_hit
);
  logic          blk_q;
  logic [LW-1:0] blk_line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q      <= 1'b0;
      blk_line_q <= '0;
    end else if (set) begin
      blk_q      <= 1'b1;
      blk_line_q <= line;
    end else if (clr) begin
      blk_q <= 1'b0;
    end
  end

  assign chk_hit = blk_q && (blk_line_q == chk_line);

  p_block_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> (chk_line != $past(line)) || chk_hit);
  p_block_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !chk_hit);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int IDW        = 4,
  parameter int DEPTH      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bypass,
  input  logic           cmp_valid,
  output logic           cmp_ready,
  input  logic [2:0]     cmp_op,
  input  logic [AW-1:0]  cmp_addr,
  input  logic [IDW-1:0] cmp_id,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic           rsp_ok,
  output logic [IDW-1:0] rsp_id,
  input  logic           evict_valid,
  input  logic [AW-1:0]  evict_addr,
  input  logic [AW-1:0]  chk_addr,
  output logic           chk_blocked
);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFW;

  logic [LW-1:0] cmp_line, ev_line, chk_line;
  logic          fire, upd_en, hit_own, ok_c;
  logic          unused_low;

  assign cmp_line   = cmp_addr[AW-1:OFFW];
  assign ev_line    = evict_addr[AW-1:OFFW];
  assign chk_line   = chk_addr[AW-1:OFFW];
  assign unused_low = ^{cmp_addr[OFFW-1:0], evict_addr[OFFW-1:0], chk_addr[OFFW-1:0]};

  assign cmp_ready = !rsp_valid || rsp_ready;
  assign fire      = cmp_valid && cmp_ready;
  assign upd_en    = fire && !bypass;

  always_comb begin
    if (bypass)              ok_c = 1'b1;
    else if (cmp_op == OP_SC) ok_c = hit_own;
    else                     ok_c = 1'b1;
  end

  llsc_resv_table #(.DEPTH(DEPTH), .LW(LW), .IDW(IDW)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (evict_valid),
    .ev_line  (ev_line),
    .upd_en   (upd_en),
    .upd_op   (cmp_op),
    .upd_line (cmp_line),
    .upd_id   (cmp_id),
    .hit_own  (hit_own)
  );

  llsc_line_lock #(.LW(LW)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (fire && cmp_op == OP_LKRD),
    .clr      (fire && cmp_op == OP_LKWR),
    .line     (cmp_line),
    .chk_line (chk_line),
    .chk_hit  (chk_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_id    <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_ok    <= ok_c;
      rsp_id    <= cmp_id;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_id));
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  p_bypass_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bypass) |=> rsp_ok);
  p_non_sc_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmp_op != OP_SC) |=> rsp_ok);
endmodule

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  localparam int AW = 16, IDW = 4;

  logic clk = 1'b0, rst_n = 1'b0, bypass = 1'b0;
  logic cmp_valid = 1'b0, cmp_ready, rsp_valid, rsp_ready = 1'b1, rsp_ok;
  logic [2:0] cmp_op = '0;
  logic [AW-1:0] cmp_addr = '0, evict_addr = '0, chk_addr = '0;
  logic [IDW-1:0] cmp_id = '0, rsp_id;
  logic evict_valid = 1'b0, chk_blocked;

  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  llsc_monitor #(.AW(AW), .LINE_BYTES(64), .IDW(IDW), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_op(cmp_op),
    .cmp_addr(cmp_addr), .cmp_id(cmp_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_id(rsp_id),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .chk_addr(chk_addr), .chk_blocked(chk_blocked)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bypass = 1'b0; cmp_valid = 1'b0; evict_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one completion, optionally with an eviction in the same cycle
  task automatic op_ev(input logic [2:0] op, input logic [AW-1:0] a, input logic [IDW-1:0] id,
                       input logic ev, input logic [AW-1:0] ea, input logic exp_ok, input string tag);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_op = op; cmp_addr = a; cmp_id = id;
    evict_valid = ev; evict_addr = ea;
    @(posedge clk);
    #1;
    cmp_valid = 1'b0; evict_valid = 1'b0;
    check({31'd0, rsp_valid}, 32'd1, {tag, " rsp_valid"});
    check({31'd0, rsp_ok}, {31'd0, exp_ok}, {tag, " rsp_ok"});
    check({28'd0, rsp_id}, {28'd0, id}, {tag, " rsp_id"});
  endtask

  task automatic op(input logic [2:0] o, input logic [AW-1:0] a, input logic [IDW-1:0] id,
                    input logic exp_ok, input string tag);
    op_ev(o, a, id, 1'b0, '0, exp_ok, tag);
  endtask

  task automatic evict(input logic [AW-1:0] a);
    @(negedge clk);
    evict_valid = 1'b1; evict_addr = a;
    @(posedge clk);
    #1 evict_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check({31'd0, rsp_valid}, 32'd0, "R11 rsp_valid after reset");
    check({31'd0, cmp_ready}, 32'd1, "R11 cmp_ready after reset");
    chk_addr = 16'h0000;
    #1 check({31'd0, chk_blocked}, 32'd0, "R11 no block after reset");
    op(3'd1, 16'h0000, 4'd0, 1'b0, "R11 SC on empty table fails");
  endtask

  task automatic t_ll_sc();
    do_reset();
    op(3'd0, 16'h0100, 4'd1, 1'b1, "R1 LL ok");
    op(3'd1, 16'h0104, 4'd1, 1'b1, "R2 SC same id same line ok");
    op(3'd1, 16'h0100, 4'd1, 1'b0, "R3 second SC fails after clear");
    op(3'd0, 16'h0200, 4'd1, 1'b1, "R1 LL ok");
    op(3'd1, 16'h0208, 4'd2, 1'b0, "R2 R10 SC other id fails");
    op(3'd1, 16'h0200, 4'd1, 1'b0, "R3 failed SC cleared owner");
  endtask

  task automatic t_write();
    do_reset();
    op(3'd0, 16'h0300, 4'd1, 1'b1, "R1 LL");
    op(3'd2, 16'h0310, 4'd2, 1'b1, "R4 other id write ok");
    op(3'd1, 16'h0300, 4'd1, 1'b1, "R4 other id write left reservation");
    op(3'd0, 16'h0300, 4'd1, 1'b1, "R1 LL");
    op(3'd2, 16'h0304, 4'd1, 1'b1, "R4 own write ok");
    op(3'd1, 16'h0300, 4'd1, 1'b0, "R4 own write cleared");
    op(3'd0, 16'h0300, 4'd3, 1'b1, "R1 LL");
    op(3'd6, 16'h0300, 4'd3, 1'b1, "R4 code 6 acts as write");
    op(3'd1, 16'h0300, 4'd3, 1'b0, "R4 code 6 cleared");
  endtask

  task automatic t_replace();
    do_reset();
    for (int k = 0; k < 5; k++) op(3'd0, AW'(16'h0400 + k * 64), 4'd1, 1'b1, "R5 LL fill");
    op(3'd1, 16'h0400, 4'd1, 1'b0, "R5 oldest line replaced");
    op(3'd1, 16'h0440, 4'd1, 1'b1, "R5 second line kept");
    do_reset();
    for (int k = 0; k < 4; k++) op(3'd0, AW'(16'h0400 + k * 64), 4'd1, 1'b1, "R5 LL fill");
    op(3'd0, 16'h0400, 4'd2, 1'b1, "R5 LL refresh other id");
    op(3'd0, 16'h0500, 4'd1, 1'b1, "R5 LL fifth line");
    op(3'd1, 16'h0400, 4'd2, 1'b1, "R5 refreshed line reassigned and kept");
    op(3'd1, 16'h0440, 4'd1, 1'b0, "R5 next oldest replaced");
    op(3'd1, 16'h0480, 4'd1, 1'b1, "R5 third line kept");
  endtask

  task automatic t_evict();
    do_reset();
    op(3'd0, 16'h0600, 4'd3, 1'b1, "R1 LL");
    evict(16'h0610);
    op(3'd1, 16'h0600, 4'd3, 1'b0, "R6 evicted line SC fails");
    op(3'd0, 16'h0600, 4'd3, 1'b1, "R1 LL");
    evict(16'h0640);
    op(3'd1, 16'h0600, 4'd3, 1'b1, "R6 other line eviction no effect");
    op(3'd0, 16'h0600, 4'd3, 1'b1, "R1 LL");
    op_ev(3'd1, 16'h0600, 4'd3, 1'b1, 16'h0600, 1'b0, "R6 eviction first same cycle");
  endtask

  task automatic t_lock();
    do_reset();
    chk_addr = 16'h0720;
    op(3'd0, 16'h0700, 4'd1, 1'b1, "R1 LL");
    op(3'd3, 16'h0708, 4'd1, 1'b1, "R7 locked read ok");
    check({31'd0, chk_blocked}, 32'd1, "R7 line blocked");
    chk_addr = 16'h0740;
    #1 check({31'd0, chk_blocked}, 32'd0, "R7 other line not blocked");
    chk_addr = 16'h0700;
    op(3'd1, 16'h0700, 4'd1, 1'b0, "R7 locked read cleared own reservation");
    check({31'd0, chk_blocked}, 32'd1, "R7 block held");
    op(3'd4, 16'h0700, 4'd1, 1'b1, "R7 locked write ok");
    check({31'd0, chk_blocked}, 32'd0, "R7 unblocked");
  endtask

  task automatic t_bypass();
    do_reset();
    op(3'd0, 16'h0800, 4'd1, 1'b1, "R1 LL");
    bypass = 1'b1;
    op(3'd1, 16'h0800, 4'd2, 1'b1, "R8 bypass SC other id ok");
    op(3'd1, 16'h0900, 4'd2, 1'b1, "R8 bypass SC unreserved ok");
    op(3'd2, 16'h0800, 4'd1, 1'b1, "R8 bypass own write ok");
    op(3'd0, 16'h0a00, 4'd1, 1'b1, "R8 bypass LL ok");
    bypass = 1'b0;
    op(3'd1, 16'h0800, 4'd1, 1'b1, "R8 reservation untouched in bypass");
    op(3'd1, 16'h0a00, 4'd1, 1'b0, "R8 bypass LL created nothing");
  endtask

  task automatic t_backpressure();
    do_reset();
    @(negedge clk);
    rsp_ready = 1'b0;
    cmp_valid = 1'b1; cmp_op = 3'd1; cmp_addr = 16'h0b00; cmp_id = 4'd5;
    @(posedge clk);
    #1;
    check({31'd0, rsp_valid}, 32'd1, "R9 result next cycle");
    check({31'd0, rsp_ok}, 32'd0, "R9 first result");
    @(negedge clk);
    cmp_op = 3'd0; cmp_addr = 16'h0c00; cmp_id = 4'd6;
    #1 check({31'd0, cmp_ready}, 32'd0, "R9 not ready while result waits");
    @(posedge clk);
    @(posedge clk);
    #1;
    check({31'd0, rsp_valid}, 32'd1, "R9 result held");
    check({31'd0, rsp_ok}, 32'd0, "R9 ok stable");
    check({28'd0, rsp_id}, 32'd5, "R9 id stable");
    @(negedge clk);
    rsp_ready = 1'b1;
    #1 check({31'd0, cmp_ready}, 32'd1, "R9 ready follows rsp_ready");
    @(posedge clk);
    #1;
    cmp_valid = 1'b0;
    check({31'd0, rsp_ok}, 32'd1, "R9 second result");
    check({28'd0, rsp_id}, 32'd6, "R9 second id");
    op(3'd1, 16'h0c00, 4'd6, 1'b1, "R9 stalled LL applied once");
  endtask

  initial begin
    t_reset();
    t_ll_sc();
    t_write();
    t_replace();
    t_evict();
    t_lock();
    t_bypass();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule